// File: doc/BRIEF.md
# Multi-Drop Address-Filtering Serial Receiver

This block is an asynchronous serial receiver for a shared multi-drop line. On that line every station hears every frame. Each frame carries eight data bits and a ninth tag bit. A tag of 1 marks the frame as a station address (an ID frame). A tag of 0 marks it as payload (a data frame).

The receiver times the line with a baud tick that runs at sixteen times the bit rate. It finds the falling edge of a start bit and confirms it at mid-bit. It then samples each following bit at the middle of its period and checks the stop bit. Frames that pass the stop check and the address filter are copied into a receive buffer, and a one-cycle completion pulse is raised.

ID frames are always accepted and set an ID flag. Software compares the address itself. If the address does not match, software clears the data-accept control. Data frames are then dropped silently until the next ID frame arrives. The serial input is assumed to be already synchronous to the clock.

The control state machine has five states:

- `ST_IDLE` waits for a low line on a tick.
- `ST_START` counts half a bit, then either confirms the start (to `ST_DATA`) or rejects a false start (back to `ST_IDLE`).
- `ST_DATA` collects the eight data bits, then goes to `ST_MPB`.
- `ST_MPB` samples the tag bit, then goes to `ST_STOP`.
- `ST_STOP` samples the stop bit, then returns to `ST_IDLE`.

Any state falls to `ST_IDLE` when the receiver is disarmed.

Top module: `mprx_top`

## Requirements
- R1: After reset, `rx_buf` is 0, and `id_flag`, `frame_err` and `done_irq` are 0.
- R2: The receiver is armed only while `pwr_en`, `mp_mode` and `rx_en` are all 1. While it is disarmed, the line is not watched: no frame completes and no output changes.
- R3: A start is detected on a tick with the line low while idle. It is confirmed 8 ticks later. If the line is high at that point, it is a false start: the receiver returns to idle and nothing is reported.
- R4: The frame is sent least significant bit first, in this order: start, D0 to D7, the tag bit, then the stop bit. Each bit is sampled 16 ticks after the previous sample.
- R5: A frame with tag 1 and a high stop bit is an ID frame. It loads `rx_buf`, sets `id_flag` to 1, and pulses `done_irq` high for exactly one cycle. All three happen in the cycle after the clock edge on which the stop bit is sampled.
- R6: A frame with tag 0 and a high stop bit, received while `data_en` is 1, loads `rx_buf`, clears `id_flag` and pulses `done_irq`, with the same timing as R5.
- R7: A frame with tag 0 received while `data_en` is 0 raises no `done_irq` and leaves `rx_buf` and `id_flag` unchanged. ID frames are still accepted in this case.
- R8: A stop bit sampled low sets `frame_err` and suppresses both `done_irq` and the buffer load. The next frame with a high stop bit clears `frame_err`.
- R9: Dropping any of the three arming inputs returns the receiver to idle on the next clock. The partial frame is discarded, and a frame sent after re-arming is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, synchronous to clk, idle high |
| baud_tick | input | 1 | Single-cycle strobe at 16 times the bit rate |
| pwr_en | input | 1 | Block power enable |
| mp_mode | input | 1 | Multi-drop mode select |
| rx_en | input | 1 | Receive enable |
| data_en | input | 1 | Accept data frames (tag 0) when 1 |
| rx_buf | output | 8 | Receive buffer |
| id_flag | output | 1 | Last accepted frame was an ID frame |
| frame_err | output | 1 | Last completed frame had a low stop bit |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports are a disarm that lands in the middle of a frame and a start bit that turns out to be a glitch.

In both cases the line has to move in step with the baud tick, not with the clock. The bench therefore drives the serial line with a task that counts tick strobes for every bit. It cuts a frame short by dropping `rx_en` after a chosen number of bits, and it makes a glitch by holding the line low for only a few ticks. After each of these, a clean frame follows, to show that no stale state is left behind.

A behavioural model is compared against the outputs on every clock.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MPB,
        ST_STOP
    } rx_state_t;

endpackage

// File: rtl/mprx_ctrl.sv
module mprx_ctrl
    import mprx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      armed,
    input  logic      baud_tick,
    input  logic      rx_in,
    output logic      smp_data,
    output logic      smp_mp,
    output logic      smp_stop,
    output rx_state_t state_o
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int BIT_W = $clog2(DATA_BITS + 1);
    localparam logic [CNT_W-1:0] OS_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] OS_HALF = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

    rx_state_t        state, state_n;
    logic [CNT_W-1:0] os_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic             at_mid;

    assign at_mid  = baud_tick && (os_cnt == OS_LAST);
    assign state_o = state;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (baud_tick && !rx_in) state_n = ST_START;
            ST_START: if (baud_tick && os_cnt == OS_HALF)
                          state_n = rx_in ? ST_IDLE : ST_DATA;
            ST_DATA:  if (at_mid && bit_cnt == BIT_LAST) state_n = ST_MPB;
            ST_MPB:   if (at_mid) state_n = ST_STOP;
            ST_STOP:  if (at_mid) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
        if (!armed) state_n = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // oversample and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
        end else begin
            if (!armed || state_n != state)
                os_cnt <= '0;
            else if (baud_tick)
                os_cnt <= (os_cnt == OS_LAST) ? '0 : os_cnt + 1'b1;

            if (state != ST_DATA)
                bit_cnt <= '0;
            else if (smp_data)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // sample strobes
    always_comb begin
        smp_data = 1'b0;
        smp_mp   = 1'b0;
        smp_stop = 1'b0;
        if (armed && at_mid) begin
            unique case (state)
                ST_DATA: smp_data = 1'b1;
                ST_MPB:  smp_mp   = 1'b1;
                ST_STOP: smp_stop = 1'b1;
                default: ;
            endcase
        end
    end

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> state == ST_IDLE);

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smp_data, smp_mp, smp_stop}));

    assert_bit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DATA |-> bit_cnt < BIT_W'(DATA_BITS));

    assert_false_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && armed && baud_tick && os_cnt == OS_HALF && rx_in)
        |=> state == ST_IDLE);

endmodule

// File: rtl/mprx_shifter.sv
module mprx_shifter #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_in,
    input  logic                 smp_data,
    input  logic                 smp_mp,
    output logic [DATA_BITS-1:0] word_o,
    output logic                 tag_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o <= '0;
            tag_o  <= 1'b0;
        end else begin
            if (smp_data) word_o <= {rx_in, word_o[DATA_BITS-1:1]};
            if (smp_mp)   tag_o  <= rx_in;
        end
    end

endmodule

// File: rtl/mprx_filter.sv
module mprx_filter #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stop,
    input  logic                 rx_in,
    input  logic [DATA_BITS-1:0] word_i,
    input  logic                 tag_i,
    input  logic                 data_en,
    output logic [DATA_BITS-1:0] rx_buf,
    output logic                 id_flag,
    output logic                 frame_err,
    output logic                 done_irq
);

    logic accept_id, accept_data, bad_stop;

    always_comb begin
        bad_stop    = smp_stop && !rx_in;
        accept_id   = smp_stop && rx_in && tag_i;
        accept_data = smp_stop && rx_in && !tag_i && data_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf    <= '0;
            id_flag   <= 1'b0;
            frame_err <= 1'b0;
            done_irq  <= 1'b0;
        end else begin
            done_irq <= accept_id || accept_data;
            if (bad_stop)                    frame_err <= 1'b1;
            else if (smp_stop)               frame_err <= 1'b0;
            if (accept_id || accept_data)    rx_buf    <= word_i;
            if (accept_id)                   id_flag   <= 1'b1;
            else if (accept_data)            id_flag   <= 1'b0;
        end
    end

    assert_irq_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !frame_err);

    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    assert_data_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq && !id_flag) |-> $past(data_en));

    assert_buf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_irq |-> $stable(rx_buf));

    assert_id_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_flag) |-> done_irq);

endmodule

// File: rtl/mprx_top.sv
module mprx_top
    import mprx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_in,
    input  logic                 baud_tick,
    input  logic                 pwr_en,
    input  logic                 mp_mode,
    input  logic                 rx_en,
    input  logic                 data_en,
    output logic [DATA_BITS-1:0] rx_buf,
    output logic                 id_flag,
    output logic                 frame_err,
    output logic                 done_irq
);

    logic                 armed;
    logic                 smp_data, smp_mp, smp_stop;
    logic [DATA_BITS-1:0] word;
    logic                 tag;
    rx_state_t            state;

    assign armed = pwr_en && mp_mode && rx_en;

    mprx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .armed(armed), .baud_tick(baud_tick),
        .rx_in(rx_in), .smp_data(smp_data), .smp_mp(smp_mp),
        .smp_stop(smp_stop), .state_o(state)
    );

    mprx_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .smp_data(smp_data),
        .smp_mp(smp_mp), .word_o(word), .tag_o(tag)
    );

    mprx_filter #(.DATA_BITS(DATA_BITS)) u_filt (
        .clk(clk), .rst_n(rst_n), .smp_stop(smp_stop), .rx_in(rx_in),
        .word_i(word), .tag_i(tag), .data_en(data_en), .rx_buf(rx_buf),
        .id_flag(id_flag), .frame_err(frame_err), .done_irq(done_irq)
    );

    assert_disarmed_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && state == ST_IDLE) |=> !done_irq);

endmodule

// File: tb/mprx_top_tb.sv
module mprx_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       baud_tick = 1'b0;
    logic       pwr_en = 1'b0, mp_mode = 1'b0, rx_en = 1'b0, data_en = 1'b0;
    logic [7:0] rx_buf;
    logic       id_flag, frame_err, done_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int cycles = 0;
    int tdiv = 0;
    string cur_req = "R1";

    mprx_top u_dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
        .pwr_en(pwr_en), .mp_mode(mp_mode), .rx_en(rx_en), .data_en(data_en),
        .rx_buf(rx_buf), .id_flag(id_flag), .frame_err(frame_err),
        .done_irq(done_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == TICK_DIV - 1);
    end

    // behavioural reference model
    int       m_phase = 0;
    int       m_cnt = 0;
    int       m_idx = 0;
    bit [9:0] m_bits = '0;
    bit [7:0] m_buf = '0;
    bit       m_id = 0, m_err = 0, m_irq = 0;

    always @(posedge clk) begin
        m_irq = 0;
        if (!rst_n) begin
            m_phase = 0; m_buf = 0; m_id = 0; m_err = 0;
        end else if (!(pwr_en && mp_mode && rx_en)) begin
            m_phase = 0;
        end else if (baud_tick) begin
            if (m_phase == 0) begin
                if (!rx_in) begin m_phase = 1; m_cnt = 0; end
            end else if (m_phase == 1) begin
                m_cnt++;
                if (m_cnt == 8) begin
                    if (rx_in) m_phase = 0;
                    else begin m_phase = 2; m_cnt = 0; m_idx = 0; end
                end
            end else begin
                m_cnt++;
                if (m_cnt == 16) begin
                    m_cnt = 0;
                    m_bits[m_idx] = rx_in;
                    m_idx++;
                    if (m_idx == 10) begin
                        m_phase = 0;
                        if (!m_bits[9]) m_err = 1;
                        else begin
                            m_err = 0;
                            if (m_bits[8]) begin
                                m_buf = m_bits[7:0]; m_id = 1; m_irq = 1;
                            end else if (data_en) begin
                                m_buf = m_bits[7:0]; m_id = 0; m_irq = 1;
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // compare against model every clock
    always @(negedge clk) begin
        cycles++;
        if (done_irq) irq_cnt++;
        chk(cur_req, "rx_buf",    rx_buf,    m_buf);
        chk(cur_req, "id_flag",   id_flag,   m_id);
        chk(cur_req, "frame_err", frame_err, m_err);
        chk(cur_req, "done_irq",  done_irq,  m_irq);
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic send_bit(bit v);
        int n = 0;
        rx_in = v;
        while (n < 16) begin
            @(posedge clk);
            if (baud_tick) n++;
        end
        @(negedge clk);
    endtask

    task automatic send_frame(bit [7:0] d, bit tag, bit stop);
        send_bit(0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(tag);
        send_bit(stop);
        send_bit(1);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset buf", rx_buf, 0);
        chk("R1", "reset irq", done_irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disarmed (mode off) line is ignored
        cur_req = "R2";
        pwr_en = 1; rx_en = 1; data_en = 1;
        base = irq_cnt;
        send_frame(8'hA5, 1, 1);
        chk("R2", "no irq when disarmed", irq_cnt - base, 0);
        chk("R2", "buf untouched", rx_buf, 0);

        // R5/R4: ID frame
        cur_req = "R5";
        mp_mode = 1;
        base = irq_cnt;
        send_frame(8'h5A, 1, 1);
        chk("R5", "id irq count", irq_cnt - base, 1);
        chk("R4", "id buf LSB first", rx_buf, 8'h5A);
        chk("R5", "id flag", id_flag, 1);

        // R6: data frame accepted
        cur_req = "R6";
        base = irq_cnt;
        send_frame(8'hC3, 0, 1);
        chk("R6", "data irq", irq_cnt - base, 1);
        chk("R6", "data buf", rx_buf, 8'hC3);
        chk("R6", "id flag cleared", id_flag, 0);

        // R7: data filtered, ID still accepted
        cur_req = "R7";
        data_en = 0;
        base = irq_cnt;
        send_frame(8'h11, 0, 1);
        chk("R7", "filtered irq", irq_cnt - base, 0);
        chk("R7", "filtered buf", rx_buf, 8'hC3);
        chk("R7", "filtered id flag", id_flag, 0);
        send_frame(8'h3C, 1, 1);
        chk("R7", "id accepted while filtered", rx_buf, 8'h3C);
        chk("R7", "id irq while filtered", irq_cnt - base, 1);
        data_en = 1;

        // R8: bad stop, then recovery
        cur_req = "R8";
        base = irq_cnt;
        send_frame(8'h77, 1, 0);
        chk("R8", "ferr set", frame_err, 1);
        chk("R8", "no irq on ferr", irq_cnt - base, 0);
        chk("R8", "buf kept", rx_buf, 8'h3C);
        send_frame(8'h81, 0, 1);
        chk("R8", "ferr cleared", frame_err, 0);
        chk("R8", "buf after recovery", rx_buf, 8'h81);

        // R3: false start
        cur_req = "R3";
        base = irq_cnt;
        rx_in = 0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rx_in = 1;
        repeat (40 * TICK_DIV) @(negedge clk);
        chk("R3", "glitch no irq", irq_cnt - base, 0);
        send_frame(8'hE7, 1, 1);
        chk("R3", "frame after glitch", rx_buf, 8'hE7);

        // R9: abort mid frame
        cur_req = "R9";
        base = irq_cnt;
        send_bit(0);
        send_bit(1); send_bit(0); send_bit(1);
        rx_en = 0;
        rx_in = 1;
        repeat (10) @(negedge clk);
        rx_en = 1;
        repeat (20 * TICK_DIV) @(negedge clk);
        chk("R9", "abort no irq", irq_cnt - base, 0);
        send_frame(8'h26, 0, 1);
        chk("R9", "frame after abort", rx_buf, 8'h26);
        chk("R9", "irq after abort", irq_cnt - base, 1);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule